// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip requester and an external 32K x 8 asynchronous static RAM. The requester presents a word address, a direction flag and, for writes, a data byte. The controller takes the request in one clock edge and then generates the active-low chip-select, write-enable and output-enable strobes. It drives the 15-bit address and decides when the shared 8-bit data bus is driven from this side. When the access is complete, it returns a one-cycle acknowledge, together with the captured byte for a read.

All analog intervals are given in nanoseconds and turned into clock-cycle counts at elaboration time, with each count rounded up. These intervals are the address setup before the write window, the width of the write window, the recovery after it, the read access time and the minimum cycle length. A write is framed as setup, then the window with both strobes low, then recovery. The recovery is stretched when needed so that the whole write meets the minimum cycle. A read holds output-enable low for the longer of the access time and the minimum cycle. When the bus changes direction between two accesses, the controller inserts a dead cycle with every strobe high. With nothing to do, the part is kept deselected in standby.

The pad logic outside this block combines the data bus output, its enable and the returned input into the bidirectional pins.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it, chip-select, write-enable and output-enable are high, the bus enable is low, `req_ready` is high and `rsp_ack` is low.
- R2: With no request, the part stays deselected. All three strobes are high and the bus enable is low. Whenever chip-select is high, the other two strobes are high and the bus is released.
- R3: A write opens with exactly SETUP cycles in which chip-select is low and write-enable and output-enable are high, before write-enable falls. The address stays unchanged for the entire time chip-select is low.
- R4: Write-enable stays low for exactly PULSE consecutive cycles. During those cycles chip-select is low, output-enable is high and the bus is driven with the request's data byte.
- R5: After write-enable rises, chip-select stays low with the address and data held for REC cycles. REC is the recovery count, raised if needed so that SETUP + PULSE + REC reaches the minimum cycle count.
- R6: A read holds chip-select and output-enable low, with write-enable high and the bus released, for READ cycles. READ is the larger of the access count and the minimum cycle count. `rsp_rdata` returns the byte present on `mem_dq_in` in the last of those cycles.
- R7: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_ack` is high for exactly one cycle: the cycle after the last strobe cycle of the access.
- R8: If an access goes in the opposite direction to the previous one (read after write or write after read), one cycle with all strobes high and the bus released comes before it. Accesses in the same direction get no such cycle, and neither does the first access after reset.
- R9: The bus is never driven while output-enable is low.
- R10: The bus enable is high only while chip-select is low and output-enable is high.
- R11: All 15 address bits reach the memory, so the lowest word (0x0000) and the highest word (0x7FFF) are separate locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 15 | Memory address lines |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_dq_out | output | 8 | Byte to place on the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte read back from the data pins |

## Verification
At the defaults (10 ns clock), SETUP is 1, PULSE is 4, REC is stretched from 1 to 2, and READ is 7 cycles. The strobes are registered from the next-state decode, so the first strobe cycle follows the accepting edge directly. Counting falling edges after that edge, the acknowledge is due on edge 8 for an access with no turnaround and on edge 9 when a turnaround cycle is inserted. The bench samples every output on the falling edge and sorts each cycle of an access by its strobe pattern before checking the counts. For a read, it checks the returned byte on the acknowledge edge itself, and on the next edge it checks that the acknowledge has dropped and the strobes are back in standby.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_SETUP = 3'd2,
    ST_PULSE = 3'd3,
    ST_RECOV = 3'd4,
    ST_READ  = 3'd5
  } ctrl_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } bus_dir_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    if (period_ns == 0) return 1;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Recovery count stretched so that the whole write meets the cycle minimum.
  function automatic int unsigned rec_stretch(input int unsigned rec, input int unsigned cyc_min,
                                              input int unsigned setup, input int unsigned pulse);
    if (cyc_min > setup + pulse) return max_u(rec, cyc_min - setup - pulse);
    return rec;
  endfunction

  // Pin pattern for each controller state.
  function automatic strobe_t strobe_decode(input ctrl_state_e s);
    strobe_t p;
    p = STROBE_IDLE;
    case (s)
      ST_SETUP: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
      ST_PULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_RECOV: begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
      ST_READ:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
      default:  p = STROBE_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 4,
  parameter int unsigned REC_CYC   = 2,
  parameter int unsigned READ_CYC  = 7,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_last,
  output ctrl_state_e      state_q,
  output ctrl_state_e      state_nxt,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             rd_capture,
  output logic             op_done
);

  bus_dir_e dir_q;
  logic     op_wr_q;
  logic     turn_req;

  function automatic int unsigned phase_len(input ctrl_state_e s);
    case (s)
      ST_SETUP: return SETUP_CYC;
      ST_PULSE: return PULSE_CYC;
      ST_RECOV: return REC_CYC;
      ST_READ:  return READ_CYC;
      default:  return 1;
    endcase
  endfunction

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    turn_req = ((dir_q == DIR_WR) && !req_write) || ((dir_q == DIR_RD) && req_write);
  end

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (turn_req)       state_nxt = ST_TURN;
          else if (req_write) state_nxt = ST_SETUP;
          else                state_nxt = ST_READ;
        end
      end
      ST_TURN:  state_nxt = op_wr_q ? ST_SETUP : ST_READ;
      ST_SETUP: if (phase_last) state_nxt = ST_PULSE;
      ST_PULSE: if (phase_last) state_nxt = ST_RECOV;
      ST_RECOV: if (phase_last) state_nxt = ST_IDLE;
      ST_READ:  if (phase_last) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  assign timer_load = (state_nxt != state_q);
  assign timer_val  = CNT_W'(phase_len(state_nxt) - 1);
  assign rd_capture = (state_q == ST_READ) && phase_last;
  assign op_done    = ((state_q == ST_READ) || (state_q == ST_RECOV)) && phase_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_NONE;
      op_wr_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (accept) begin
        op_wr_q <= req_write;
        dir_q   <= req_write ? DIR_WR : DIR_RD;
      end
    end
  end

endmodule

// File: rtl/sram_bus_datapath.sv
module sram_bus_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  ctrl_state_e       state_nxt,
  input  logic              rd_capture,
  input  logic              op_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output strobe_t           pins,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  strobe_t           pins_q;
  logic              ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      pins_q  <= STROBE_IDLE;
      ack_q   <= 1'b0;
    end else begin
      pins_q <= strobe_decode(state_nxt);
      ack_q  <= op_done;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rdata_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign pins       = pins_q;
  assign rsp_ack    = ack_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned ADDR_SETUP_NS = 10,
  parameter int unsigned WR_PULSE_NS   = 40,
  parameter int unsigned WR_RECOV_NS   = 10,
  parameter int unsigned RD_ACCESS_NS  = 55,
  parameter int unsigned CYCLE_MIN_NS  = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned CYC_MIN   = ns_to_cyc(CYCLE_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = ns_to_cyc(WR_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC   = rec_stretch(ns_to_cyc(WR_RECOV_NS, CLK_PERIOD_NS),
                                                  CYC_MIN, SETUP_CYC, PULSE_CYC);
  localparam int unsigned READ_CYC  = max_u(ns_to_cyc(RD_ACCESS_NS, CLK_PERIOD_NS), CYC_MIN);
  localparam int unsigned WR_TOTAL  = SETUP_CYC + PULSE_CYC + REC_CYC;
  localparam int unsigned MAX_LEN   = max_u(max_u(SETUP_CYC, PULSE_CYC), max_u(REC_CYC, READ_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1);

  // Internal events, named for the bound checker.
  ctrl_state_e      state_w;
  ctrl_state_e      state_nxt_w;
  logic             accept_w;
  logic             timer_load_w;
  logic [CNT_W-1:0] timer_val_w;
  logic             phase_last_w;
  logic             rd_capture_w;
  logic             op_done_w;
  strobe_t          pins_w;

  sram_access_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .READ_CYC  (READ_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_last (phase_last_w),
    .state_q    (state_w),
    .state_nxt  (state_nxt_w),
    .accept     (accept_w),
    .timer_load (timer_load_w),
    .timer_val  (timer_val_w),
    .rd_capture (rd_capture_w),
    .op_done    (op_done_w)
  );

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load_w),
    .load_val (timer_val_w),
    .last     (phase_last_w)
  );

  sram_bus_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept_w),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .state_nxt  (state_nxt_w),
    .rd_capture (rd_capture_w),
    .op_done    (op_done_w),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .pins       (pins_w),
    .rsp_ack    (rsp_ack),
    .rsp_rdata  (rsp_rdata)
  );

  assign req_ready = (state_w == ST_IDLE);
  assign mem_cs_n  = pins_w.cs_n;
  assign mem_we_n  = pins_w.we_n;
  assign mem_oe_n  = pins_w.oe_n;
  assign mem_dq_oe = pins_w.dq_oe;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 4,
  parameter int unsigned WR_TOTAL  = 7,
  parameter int unsigned READ_CYC  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              accept,
  input logic              rd_capture
);

  logic        cs_d;
  logic        we_d;
  logic        saw_we;
  logic [31:0] cs_run;
  logic [31:0] we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      we_d   <= 1'b1;
      saw_we <= 1'b0;
      cs_run <= '0;
      we_run <= '0;
    end else begin
      cs_d   <= mem_cs_n;
      we_d   <= mem_we_n;
      cs_run <= mem_cs_n ? 32'd0 : cs_run + 32'd1;
      we_run <= mem_we_n ? 32'd0 : we_run + 32'd1;
      saw_we <= !mem_we_n ? 1'b1 : (mem_cs_n ? 1'b0 : saw_we);
    end
  end

  // R2
  p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe))
    else $error("standby strobes wrong");

  // R3
  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && we_d) |-> (cs_run == SETUP_CYC))
    else $error("address setup count wrong");

  // R3
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !cs_d) |-> $stable(mem_addr))
    else $error("address moved while selected");

  // R4
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !we_d) |-> (we_run == PULSE_CYC))
    else $error("write window width wrong");

  // R4
  p_wdrive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe))
    else $error("write window strobes wrong");

  // R5 and R6: length of the selected interval
  p_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n && !cs_d) |-> (cs_run == (saw_we ? WR_TOTAL : READ_CYC)))
    else $error("access length wrong");

  // R6
  p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n && !mem_dq_oe))
    else $error("read strobes wrong");

  // R6
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_ack)
    else $error("capture not followed by ack");

  // R7
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack)
    else $error("ack longer than one cycle");

  // R7
  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n)
    else $error("ready while selected");

  // R7
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready)
    else $error("still ready after accept");

  // R9
  p_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n))
    else $error("bus contention");

  // R10
  p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n))
    else $error("bus driven outside a write");

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .WR_TOTAL  (WR_TOTAL),
  .READ_CYC  (READ_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_ack    (rsp_ack),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .accept     (accept_w),
  .rd_capture (rd_capture_w)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int PER = 10;
  localparam int AS  = 10;
  localparam int PW  = 40;
  localparam int RC  = 10;
  localparam int RA  = 55;
  localparam int CM  = 70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_ack;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int n_tests = 0;
  int n_fail  = 0;
  int bus_err = 0;
  int e_setup, e_pulse, e_rec, e_read;

  logic [7:0]  mdl_mem [0:255];
  logic        prev_ovl = 1'b0;
  logic [7:0]  ovl_data = '0;
  logic [14:0] ovl_addr = '0;

  always #5 clk = ~clk;

  sram_async_ctrl #(
    .CLK_PERIOD_NS (PER), .ADDR_SETUP_NS (AS), .WR_PULSE_NS (PW),
    .WR_RECOV_NS (RC), .RD_ACCESS_NS (RA), .CYCLE_MIN_NS (CM)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_ack (rsp_ack), .rsp_rdata (rsp_rdata), .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
    .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  // Memory model: drives data only when selected for reading.
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mdl_mem[mem_addr[7:0]] : 8'h5A;

  // Write lands when the selected-and-write-enabled overlap ends; bus monitor.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) bus_err++;
      if (mem_dq_oe && mem_cs_n) bus_err++;
      if (!mem_cs_n && !mem_we_n) begin
        ovl_data = mem_dq_out;
        ovl_addr = mem_addr;
        prev_ovl = 1'b1;
      end else if (prev_ovl) begin
        mdl_mem[ovl_addr[7:0]] = ovl_data;
        prev_ovl = 1'b0;
      end
    end
  end

  function automatic int to_cyc(input int ns);
    int q;
    q = ns / PER;
    if (ns % PER != 0) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // One access; counts every strobe cycle until the acknowledge.
  task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d, input int exp_turn);
    int k = 0, turn = 0, st = 0, pw = 0, rc = 0, rd = 0;
    int ready_bad = 0, addr_bad = 0, data_bad = 0;
    bit seen_cs = 0, after_we = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wr ? d : 8'h00;
    chk("R7", "ready before request", int'(req_ready), 1);
    @(posedge clk);
    while (k < 60) begin
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      if (rsp_ack) break;
      if (req_ready) ready_bad++;
      if (mem_cs_n) begin
        if (!seen_cs) turn++;
      end else begin
        seen_cs = 1;
        if (mem_addr != a) addr_bad++;
        if (!mem_oe_n) rd++;
        else if (!mem_we_n) begin
          pw++; after_we = 1;
          if (!mem_dq_oe || mem_dq_out != d) data_bad++;
        end else if (after_we) begin
          rc++;
          if (!mem_dq_oe || mem_dq_out != d) data_bad++;
        end else st++;
      end
    end
    chk("R7", "ack latency", k, exp_turn + (wr ? e_setup + e_pulse + e_rec : e_read) + 1);
    chk("R8", "turnaround cycles", turn, exp_turn);
    chk("R7", "ready low while busy", ready_bad, 0);
    chk("R3", "address held", addr_bad, 0);
    if (wr) begin
      chk("R3", "setup cycles", st, e_setup);
      chk("R4", "write window cycles", pw, e_pulse);
      chk("R5", "recovery cycles", rc, e_rec);
      chk("R4", "data driven", data_bad, 0);
      chk("R4", "output enable high", rd, 0);
    end else begin
      chk("R6", "read cycles", rd, e_read);
      chk("R6", "no write window", pw, 0);
      chk("R6", "read data", int'(rsp_rdata), int'(d));
    end
    @(negedge clk);
    chk("R7", "ack one cycle", int'(rsp_ack), 0);
    chk("R2", "standby after access", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pins in reset", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready/ack after reset", int'({req_ready, rsp_ack}), 2'b10);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if ({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} != 4'b1110) bad++;
    end
    chk("R2", "idle standby cycles wrong", bad, 0);
  endtask

  task automatic t_write_low();   run_op(1'b1, 15'h0000, 8'h3C, 0); endtask
  task automatic t_write_high();  run_op(1'b1, 15'h7FFF, 8'hC3, 0); endtask
  task automatic t_read_turn();   run_op(1'b0, 15'h0000, 8'h3C, 1); endtask // R8, R11
  task automatic t_read_high();   run_op(1'b0, 15'h7FFF, 8'hC3, 0); endtask // R11
  task automatic t_write_turn();  run_op(1'b1, 15'h1234, 8'h96, 1); endtask // R8
  task automatic t_read_back();   run_op(1'b0, 15'h1234, 8'h96, 1); endtask

  task automatic t_bus();
    chk("R9", "bus contention or R10 stray drive count", bus_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
    e_setup = to_cyc(AS);
    e_pulse = to_cyc(PW);
    e_rec   = to_cyc(RC);
    if (to_cyc(CM) - e_setup - e_pulse > e_rec) e_rec = to_cyc(CM) - e_setup - e_pulse;
    e_read  = (to_cyc(RA) > to_cyc(CM)) ? to_cyc(RA) : to_cyc(CM);
    repeat (3) @(posedge clk);
    t_reset();
    t_idle();
    t_write_low();
    t_write_high();
    t_read_turn();
    t_read_high();
    t_write_turn();
    t_read_back();
    t_idle();
    t_bus();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R7 watchdog: actual %0d expected %0d cycles", 20000, 0);
    summary();
    $finish;
  end

endmodule